// File: doc/BRIEF.md
# Peripheral Interrupt Register Block

This block collects single-cycle event pulses from a peripheral's internal logic into a latched status register, masks them with a per-source enable register and a global enable, and drives one registered interrupt request. The number of implemented sources is a parameter from 0 to 32. Implemented bits occupy the low end of each register, and the unused upper bits always read as zero.

Software reaches the block through a small word-addressed register port. There is a write strobe with its own address and data, and a separate read address with combinational read data. Writing a one to a status bit inverts that bit. The same write therefore injects an event when the bit is clear, which lets software self-test the interrupt path, and acknowledges the event when the bit is set. Writing a key value to a soft-reset location returns every register to its power-on value.

The register offsets are: 0 for status (read, write-one-to-toggle), 1 for per-source enable (read/write), 2 for global enable in bit 0 (read/write), and 3 for soft reset (write-only, reads as zero).

Top module: `evt_irq_regs`

## Requirements
- R1: After hardware reset, status reads the per-bit reset-value parameter restricted to the implemented bits, enable reads 0, global enable reads 0, and irq_o is 0.
- R2: Bits at or above NUM_SRC read as zero in status and enable. Writes and event pulses on those bits have no effect.
- R3: Writing a one to a clear status bit (offset 0) sets it, and the bit stays set until changed.
- R4: Writing a one to a set status bit clears it (acknowledge). Status bits written with zero keep their value.
- R5: Enable (offset 1) reads back exactly the last value written, restricted to the implemented bits. Writing zero disables every source.
- R6: Global enable is bit 0 at offset 2, reads back as written, and all other bits of that word read zero.
- R7: irq_o equals global enable AND the OR over all bits of (status AND enable), sampled one clock after that state is present.
- R8: An event pulse on ev_in[i] (i < NUM_SRC) sets status bit i at the next clock edge, and the bit stays set after the pulse ends.
- R9: When an event pulse and a software toggle hit the same status bit in the same cycle, the bit ends up set.
- R10: Writing a value whose low 4 bits equal 0xA to offset 3 restores every register to its R1 state and drives irq_o to 0 at the same edge. Any other value written there is ignored, and offset 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | 32 | Event pulses from the peripheral, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word offset of the read |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A corrupted status or enable bit appears at rd_data in the same cycle the read address selects it. It also appears at irq_o one clock later, but only while the global enable is set and the matching partner bit is set. A stuck soft-reset decode or a wrong toggle polarity therefore stays hidden until a later read of the affected word. For this reason, every write sequence in the bench is followed by a read-back of the word it touched, and every enable change is followed by an interrupt sample exactly one clock later.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   localparam int DATA_W  = 32;
   localparam int MAX_SRC = 32;
   localparam int ADDR_W  = 2;
   localparam int KEY_W   = 4;
   localparam logic [KEY_W-1:0] SWRST_KEY = 4'hA;

   typedef enum logic [ADDR_W-1:0] {
      REG_STAT  = 2'd0,
      REG_EN    = 2'd1,
      REG_GIE   = 2'd2,
      REG_SWRST = 2'd3
   } reg_sel_e;

   // Mask with the low n bits set; valid for n in 0..32
   function automatic logic [DATA_W-1:0] impl_mask(input int n);
      logic [63:0] wide;
      wide = (64'd1 << n) - 64'd1;
      return wide[DATA_W-1:0];
   endfunction

endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
   import evt_irq_pkg::*;
(
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [KEY_W-1:0]    key_nib,
   output logic                stat_wr,
   output logic                en_wr,
   output logic                gie_wr,
   output logic                swrst_hit
);

   always_comb begin
      stat_wr   = 1'b0;
      en_wr     = 1'b0;
      gie_wr    = 1'b0;
      swrst_hit = 1'b0;
      if (wr_en) begin
         unique case (reg_sel_e'(wr_addr))
            REG_STAT:  stat_wr   = 1'b1;
            REG_EN:    en_wr     = 1'b1;
            REG_GIE:   gie_wr    = 1'b1;
            REG_SWRST: swrst_hit = (key_nib == SWRST_KEY);
            default:   ;
         endcase
      end
   end

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
   import evt_irq_pkg::*;
#(
   parameter int                NUM_SRC  = 8,
   parameter logic [DATA_W-1:0] STAT_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swrst,
   input  logic [DATA_W-1:0] ev_in,
   input  logic              tog_en,
   input  logic [DATA_W-1:0] tog_data,
   output logic [DATA_W-1:0] stat_q
);

   localparam logic [DATA_W-1:0] MASK  = impl_mask(NUM_SRC);
   localparam logic [DATA_W-1:0] RST_M = STAT_RST & MASK;

   generate
      if (NUM_SRC == 0) begin : g_none
         assign stat_q = '0;
      end else begin : g_regs
         logic [DATA_W-1:0] ev_m;
         logic [DATA_W-1:0] tog_m;
         logic [DATA_W-1:0] nxt;

         always_comb begin
            ev_m  = ev_in & MASK;
            tog_m = tog_en ? (tog_data & MASK) : '0;
            // hardware set dominates the software toggle
            nxt   = ev_m | (stat_q ^ tog_m);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     stat_q <= RST_M;
            else if (swrst) stat_q <= RST_M;
            else            stat_q <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/evt_irq_enable.sv
module evt_irq_enable
   import evt_irq_pkg::*;
#(
   parameter int NUM_SRC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swrst,
   input  logic              en_wr,
   input  logic              gie_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] en_q,
   output logic              gie_q
);

   localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_SRC);

   generate
      if (NUM_SRC == 0) begin : g_none
         assign en_q = '0;
      end else begin : g_regs
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     en_q <= '0;
            else if (swrst) en_q <= '0;
            else if (en_wr) en_q <= wdata & MASK;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      gie_q <= 1'b0;
      else if (swrst)  gie_q <= 1'b0;
      else if (gie_wr) gie_q <= wdata[0];
   end

endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out
   import evt_irq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swrst,
   input  logic              gie_q,
   input  logic [DATA_W-1:0] stat_q,
   input  logic [DATA_W-1:0] en_q,
   output logic              irq_o
);

   logic any_pend;
   assign any_pend = |(stat_q & en_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     irq_o <= 1'b0;
      else if (swrst) irq_o <= 1'b0;
      else            irq_o <= gie_q & any_pend;
   end

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
   import evt_irq_pkg::*;
#(
   parameter int                NUM_SRC  = 8,
   parameter logic [DATA_W-1:0] STAT_RST = 32'h0000_0004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       ev_in,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [1:0]        rd_addr,
   output logic [31:0]       rd_data,
   output logic              irq_o
);

   generate
      if (NUM_SRC < 0 || NUM_SRC > MAX_SRC) begin : g_bad_width
         $error("evt_irq_regs: NUM_SRC must lie in 0..32");
      end
   endgenerate

   logic              stat_wr;
   logic              en_wr;
   logic              gie_wr;
   logic              swrst_hit;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] en_q;
   logic              gie_q;

   evt_irq_decode u_dec (
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .key_nib   (wr_data[KEY_W-1:0]),
      .stat_wr   (stat_wr),
      .en_wr     (en_wr),
      .gie_wr    (gie_wr),
      .swrst_hit (swrst_hit)
   );

   evt_irq_status #(.NUM_SRC(NUM_SRC), .STAT_RST(STAT_RST)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .swrst    (swrst_hit),
      .ev_in    (ev_in),
      .tog_en   (stat_wr),
      .tog_data (wr_data),
      .stat_q   (stat_q)
   );

   evt_irq_enable #(.NUM_SRC(NUM_SRC)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .swrst  (swrst_hit),
      .en_wr  (en_wr),
      .gie_wr (gie_wr),
      .wdata  (wr_data),
      .en_q   (en_q),
      .gie_q  (gie_q)
   );

   evt_irq_out u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .swrst  (swrst_hit),
      .gie_q  (gie_q),
      .stat_q (stat_q),
      .en_q   (en_q),
      .irq_o  (irq_o)
   );

   always_comb begin
      unique case (reg_sel_e'(rd_addr))
         REG_STAT: rd_data = stat_q;
         REG_EN:   rd_data = en_q;
         REG_GIE:  rd_data = {{(DATA_W-1){1'b0}}, gie_q};
         default:  rd_data = '0;
      endcase
   end

endmodule

// File: rtl/evt_irq_regs_chk.sv
module evt_irq_regs_chk
   import evt_irq_pkg::*;
#(
   parameter int                NUM_SRC  = 8,
   parameter logic [DATA_W-1:0] STAT_RST = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       ev_in,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [31:0]       wr_data,
   input logic [DATA_W-1:0] stat_q,
   input logic [DATA_W-1:0] en_q,
   input logic              gie_q,
   input logic              swrst_hit,
   input logic              irq_o
);

   localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_SRC);

   // R2
   unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q | en_q) & ~MASK) == '0);

   // R8
   ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((ev_in & MASK) != '0) && !swrst_hit)
      |=> ((stat_q & $past(ev_in & MASK)) == $past(ev_in & MASK)));

   // R5
   en_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1) |=> (en_q == ($past(wr_data) & MASK)));

   // R7
   irq_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !swrst_hit |=> (irq_o == $past(gie_q && ((stat_q & en_q) != '0))));

   // R10
   swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swrst_hit |=> (en_q == '0 && !gie_q && !irq_o
                     && stat_q == (STAT_RST & MASK)));

endmodule

bind evt_irq_regs evt_irq_regs_chk #(.NUM_SRC(NUM_SRC), .STAT_RST(STAT_RST)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_in     (ev_in),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .stat_q    (stat_q),
   .en_q      (en_q),
   .gie_q     (gie_q),
   .swrst_hit (swrst_hit),
   .irq_o     (irq_o)
);

// File: tb/evt_irq_regs_tb_top.sv
`timescale 1ns/1ps
module evt_irq_regs_tb_top;

   localparam int          NSRC = 8;
   localparam logic [31:0] SRST = 32'h0000_0004;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] ev_in;
   logic        wr_en;
   logic [1:0]  wr_addr;
   logic [31:0] wr_data;
   logic [1:0]  rd_addr;
   logic [31:0] rd_data;
   logic        irq_o;

   always #2 clk = ~clk;

   evt_irq_regs #(.NUM_SRC(NSRC), .STAT_RST(SRST)) dut_i (
      .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_o(irq_o)
   );

   int n_chk = 0;
   int n_bad = 0;

   typedef struct packed {
      logic        wr;
      logic [1:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic        irq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b0, 2'd0, 32'h0,         32'h04, 1'b0, 4'd1},  // R1 status reset
      '{1'b0, 2'd1, 32'h0,         32'h00, 1'b0, 4'd1},  // R1 enable reset
      '{1'b0, 2'd2, 32'h0,         32'h00, 1'b0, 4'd1},  // R1 gie reset
      '{1'b1, 2'd0, 32'hFFFF_FF03, 32'h00, 1'b0, 4'd3},  // R3 inject 0,1
      '{1'b0, 2'd0, 32'h0,         32'h07, 1'b0, 4'd3},  // R3 R2 upper ignored
      '{1'b1, 2'd0, 32'h0000_0003, 32'h00, 1'b0, 4'd4},  // R4 ack
      '{1'b0, 2'd0, 32'h0,         32'h04, 1'b0, 4'd4},  // R4
      '{1'b1, 2'd1, 32'hFFFF_FFF0, 32'h00, 1'b0, 4'd5},  // R5
      '{1'b0, 2'd1, 32'h0,         32'hF0, 1'b0, 4'd5},  // R5 R2
      '{1'b1, 2'd0, 32'h0000_0010, 32'h00, 1'b0, 4'd3},  // R3
      '{1'b0, 2'd0, 32'h0,         32'h14, 1'b0, 4'd7},  // R7 gie off
      '{1'b1, 2'd2, 32'hFFFF_FFFF, 32'h00, 1'b0, 4'd6},  // R6
      '{1'b0, 2'd2, 32'h0,         32'h01, 1'b1, 4'd6},  // R6 R7
      '{1'b1, 2'd0, 32'h0000_0010, 32'h00, 1'b0, 4'd4},  // R4
      '{1'b0, 2'd0, 32'h0,         32'h04, 1'b0, 4'd7},  // R7 drop
      '{1'b1, 2'd1, 32'h0,         32'h00, 1'b0, 4'd5},  // R5 zero
      '{1'b0, 2'd1, 32'h0,         32'h00, 1'b0, 4'd5},  // R5
      '{1'b1, 2'd3, 32'h0000_0005, 32'h00, 1'b0, 4'd10}, // R10 bad key
      '{1'b0, 2'd2, 32'h0,         32'h01, 1'b0, 4'd10}, // R10 ignored
      '{1'b1, 2'd0, 32'h0000_0080, 32'h00, 1'b0, 4'd3},  // R3
      '{1'b1, 2'd3, 32'h0000_000A, 32'h00, 1'b0, 4'd10}, // R10 key
      '{1'b0, 2'd0, 32'h0,         32'h04, 1'b0, 4'd10}, // R10 status
      '{1'b0, 2'd2, 32'h0,         32'h00, 1'b0, 4'd10}  // R10 gie
   };

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%08h exp=%08h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp,
                     input string req);
      rd_addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog all-reqs act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; ev_in = '0; wr_en = 1'b0; wr_addr = '0;
      wr_data = '0; rd_addr = '0;
      repeat (3) @(negedge clk);
      check("R1 irq", {31'b0, irq_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr) begin
            wr(VECS[i].addr, VECS[i].data);
         end else begin
            rd_addr = VECS[i].addr;
            step();
            check($sformatf("R%0d vec%0d data", VECS[i].req, i),
                  rd_data, VECS[i].exp);
            check($sformatf("R%0d vec%0d irq", VECS[i].req, i),
                  {31'b0, irq_o}, {31'b0, VECS[i].irq});
         end
      end

      // R8: pulse sets and latches
      ev_in = 32'h20; step(); ev_in = '0;
      rd(2'd0, 32'h24, "R8 set");
      step();
      rd(2'd0, 32'h24, "R8 latched");
      // R2: unimplemented event ignored
      ev_in = 32'h0010_0000; step(); ev_in = '0;
      rd(2'd0, 32'h24, "R2 event");
      // R9: event and toggle collide on a set bit
      ev_in = 32'h20; wr(2'd0, 32'h20); ev_in = '0;
      rd(2'd0, 32'h24, "R9 set bit");
      // R9: collide on a clear bit
      ev_in = 32'h40; wr(2'd0, 32'h40); ev_in = '0;
      rd(2'd0, 32'h64, "R9 clear bit");
      wr(2'd0, 32'h60);
      rd(2'd0, 32'h04, "R4 ack two");
      // R7: one-cycle latency
      wr(2'd1, 32'h04);
      wr(2'd2, 32'h01);
      check("R7 latency", {31'b0, irq_o}, 32'h0);
      step();
      check("R7 asserted", {31'b0, irq_o}, 32'h1);
      wr(2'd1, 32'h0);
      step();
      check("R5 disable", {31'b0, irq_o}, 32'h0);
      rd(2'd3, 32'h0, "R10 read zero");
      // R1: hardware reset mid-run
      wr(2'd1, 32'hFF);
      rst_n = 1'b0;
      step();
      rd(2'd0, 32'h04, "R1 status");
      rd(2'd1, 32'h00, "R1 enable");
      rd(2'd2, 32'h00, "R1 gie");
      check("R1 irq hw", {31'b0, irq_o}, 32'h0);
      rst_n = 1'b1;
      step();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule